// File: doc/BRIEF.md
# Graph Unwind Unit with Sharing Propagation

This unit performs the unwind step of a graph-reduction machine. It runs when the value on top of the reduction stack points to an application node in the heap. The surrounding machine reads that node and presents it at the unit's inputs together with the pointer atom on top of the stack. In one clock cycle the unit turns that input into a set of commands. The stack top is replaced by the node's first atom. The node's remaining atoms go into the slots under the top through a masked parallel write. If the node carries case alternatives, they are pushed onto the alternatives stack. An update record is pushed onto the update stack only when the unwound pointer was shared and the node is not already in normal form.

Sharing is tracked dynamically. When the unwound pointer carried the shared flag, every atom spread onto the stack is marked shared as well. An unshared application that reaches normal form then needs no update later. A request whose atoms would not fit in the stack, or whose arity is malformed, commits nothing and raises an error pulse. A required update record that cannot be pushed because the update stack is full also raises the error pulse, but the rest of the unwind still commits.

An atom is `AW+2` bits wide: bit `AW+1` is the shared flag, bit `AW` marks a pointer, and bits `AW-1:0` hold the payload. Node atom slot k occupies bits `[k*(AW+2) +: AW+2]` of `nodeAtoms`.

Top module: `unwind_unit`

## Requirements
- R1: A request sampled at a rising edge produces its outputs in the register stage after that edge. Those outputs are valid for exactly one cycle, and the strobes drop back to zero in the next cycle unless a new request arrives.
- R2: On a committed unwind, `topWrEn` is 1 and `newTop` equals node atom slot 0, with its shared bit adjusted as in R6.
- R3: On a committed unwind, mask bit i of `stackWrMask` is 1 exactly when i < arity-1. Data slot i of `stackWrData` (bits `[i*(AW+2) +: AW+2]`) carries node atom slot i+1.
- R4: On a committed unwind of a node with `nodeHasAlts` set, `altsPush` is 1 and `altsData` equals `nodeAlts`. Otherwise `altsPush` is 0.
- R5: `updPush` is 1 only for a committed unwind in which the top atom's shared bit is 1, `nodeIsNf` is 0 and `updFull` is 0. `updData` is {`stackSize`, top payload}, with the size in the upper bits.
- R6: When the top atom's shared bit is 1, every atom written to the stack (`newTop` and all `stackWrData` slots) has bit `AW+1` set. Otherwise each atom keeps its own shared bit.
- R7: If `stackSize` + arity - 1 > `DEPTH`, the unit raises `errOverflow`. In that case `topWrEn`, `stackWrMask`, `altsPush` and `updPush` are all 0.
- R8: If an update record is required (shared top, not normal form) while `updFull` is 1, the unit raises `errOverflow` and `updPush` stays 0. The top write, the spread and the alternatives push still commit.
- R9: An arity of 0 or greater than `MAXA` is handled like R7: `errOverflow` is raised and nothing is committed.
- R10: During reset and in cycles after no request, all strobes are 0. During reset all data outputs are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| unwindReq | input | 1 | Perform an unwind this cycle |
| topAtom | input | AW+2 | Pointer atom currently on top of the stack |
| stackSize | input | SW | Current number of stack entries |
| nodeArity | input | ARW | Number of atoms in the fetched node |
| nodeAtoms | input | MAXA*(AW+2) | Atoms of the fetched node, slot 0 lowest |
| nodeHasAlts | input | 1 | Node carries case alternatives |
| nodeAlts | input | ALTW | Case alternatives reference |
| nodeIsNf | input | 1 | Node is already in normal form |
| updFull | input | 1 | Update stack cannot accept a push |
| topWrEn | output | 1 | Replace stack top with `newTop` |
| newTop | output | AW+2 | New stack top atom |
| stackWrMask | output | MAXA-1 | Per-slot write enable for slots under the top |
| stackWrData | output | (MAXA-1)*(AW+2) | Atoms for the slots under the top |
| altsPush | output | 1 | Push onto the alternatives stack |
| altsData | output | ALTW | Alternatives value to push |
| updPush | output | 1 | Push onto the update stack |
| updData | output | SW+AW | Update record {stack size, pointer} |
| errOverflow | output | 1 | Overflow or malformed-request error pulse |

## Verification
A wrong capture in the output register stage shows at the ports one cycle after the request. It appears there as a wrong atom, a mask of the wrong length, or a missing shared bit. The bench compares every output on every cycle, so the fault is reported in the cycle it occurs. A wrong decision in the control shows up as a push or an error pulse in the wrong cycle: for example an update record for an unshared node, or a spread that commits despite overflow. Directed cases cover the exact fill boundary, one entry beyond it, the malformed arities and a full update stack. These are followed by random traffic.

// File: rtl/unwind_pkg.sv
package unwind_pkg;
  typedef struct packed {
    logic spread;
    logic alts;
    logic upd;
    logic err;
  } unwindStrobes_t;
endpackage

// File: rtl/unwind_ctrl.sv
module unwind_ctrl import unwind_pkg::*; #(
  parameter int AW    = 8,
  parameter int MAXA  = 4,
  parameter int DEPTH = 16,
  localparam int ATOMW = AW + 2,
  localparam int SW    = $clog2(DEPTH + 1),
  localparam int ARW   = $clog2(MAXA + 1)
) (
  input  logic            unwindReq,
  input  logic [ATOMW-1:0] topAtom,
  input  logic [SW-1:0]   stackSize,
  input  logic [ARW-1:0]  nodeArity,
  input  logic            nodeHasAlts,
  input  logic            nodeIsNf,
  input  logic            updFull,
  output unwindStrobes_t  strobes
);
  logic legalArity;
  logic fits;
  logic commit;
  logic needUpd;

  always_comb begin
    legalArity = (int'(nodeArity) >= 1) && (int'(nodeArity) <= MAXA);
    fits       = (int'(stackSize) + int'(nodeArity) - 1) <= DEPTH;
    commit     = unwindReq && legalArity && fits;
    needUpd    = topAtom[AW+1] && !nodeIsNf;
    strobes.spread = commit;
    strobes.alts   = commit && nodeHasAlts;
    strobes.upd    = commit && needUpd && !updFull;
    strobes.err    = unwindReq && (!commit || (needUpd && updFull));
  end
endmodule

// File: rtl/unwind_dp.sv
module unwind_dp import unwind_pkg::*; #(
  parameter int AW    = 8,
  parameter int MAXA  = 4,
  parameter int DEPTH = 16,
  parameter int ALTW  = 8,
  localparam int ATOMW = AW + 2,
  localparam int SW    = $clog2(DEPTH + 1),
  localparam int ARW   = $clog2(MAXA + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  unwindStrobes_t             strobes,
  input  logic [ATOMW-1:0]           topAtom,
  input  logic [SW-1:0]              stackSize,
  input  logic [ARW-1:0]             nodeArity,
  input  logic [MAXA*ATOMW-1:0]      nodeAtoms,
  input  logic [ALTW-1:0]            nodeAlts,
  output logic                       topWrEn,
  output logic [ATOMW-1:0]           newTop,
  output logic [MAXA-2:0]            stackWrMask,
  output logic [(MAXA-1)*ATOMW-1:0]  stackWrData,
  output logic                       altsPush,
  output logic [ALTW-1:0]            altsData,
  output logic                       updPush,
  output logic [SW+AW-1:0]           updData,
  output logic                       errOverflow
);
  logic [MAXA*ATOMW-1:0] dashedAtoms;
  logic [MAXA-2:0]       maskNext;

  // Sharing propagation: a shared pointer marks every spread atom shared.
  for (genvar k = 0; k < MAXA; k++) begin : g_dash
    assign dashedAtoms[k*ATOMW +: ATOMW] =
      nodeAtoms[k*ATOMW +: ATOMW] | {topAtom[AW+1], {(ATOMW-1){1'b0}}};
  end

  for (genvar i = 0; i < MAXA - 1; i++) begin : g_mask
    assign maskNext[i] = strobes.spread && ((i + 1) < int'(nodeArity));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      topWrEn     <= 1'b0;
      newTop      <= '0;
      stackWrMask <= '0;
      stackWrData <= '0;
      altsPush    <= 1'b0;
      altsData    <= '0;
      updPush     <= 1'b0;
      updData     <= '0;
      errOverflow <= 1'b0;
    end else begin
      topWrEn     <= strobes.spread;
      newTop      <= dashedAtoms[0 +: ATOMW];
      stackWrMask <= maskNext;
      stackWrData <= dashedAtoms[ATOMW +: (MAXA-1)*ATOMW];
      altsPush    <= strobes.alts;
      altsData    <= nodeAlts;
      updPush     <= strobes.upd;
      updData     <= {stackSize, topAtom[AW-1:0]};
      errOverflow <= strobes.err;
    end
  end
endmodule

// File: rtl/unwind_unit.sv
module unwind_unit import unwind_pkg::*; #(
  parameter int AW    = 8,
  parameter int MAXA  = 4,
  parameter int DEPTH = 16,
  parameter int ALTW  = 8,
  localparam int ATOMW = AW + 2,
  localparam int SW    = $clog2(DEPTH + 1),
  localparam int ARW   = $clog2(MAXA + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       unwindReq,
  input  logic [ATOMW-1:0]           topAtom,
  input  logic [SW-1:0]              stackSize,
  input  logic [ARW-1:0]             nodeArity,
  input  logic [MAXA*ATOMW-1:0]      nodeAtoms,
  input  logic                       nodeHasAlts,
  input  logic [ALTW-1:0]            nodeAlts,
  input  logic                       nodeIsNf,
  input  logic                       updFull,
  output logic                       topWrEn,
  output logic [ATOMW-1:0]           newTop,
  output logic [MAXA-2:0]            stackWrMask,
  output logic [(MAXA-1)*ATOMW-1:0]  stackWrData,
  output logic                       altsPush,
  output logic [ALTW-1:0]            altsData,
  output logic                       updPush,
  output logic [SW+AW-1:0]           updData,
  output logic                       errOverflow
);
  unwindStrobes_t strobes;

  unwind_ctrl #(.AW(AW), .MAXA(MAXA), .DEPTH(DEPTH)) u_ctrl (
    .unwindReq  (unwindReq),
    .topAtom    (topAtom),
    .stackSize  (stackSize),
    .nodeArity  (nodeArity),
    .nodeHasAlts(nodeHasAlts),
    .nodeIsNf   (nodeIsNf),
    .updFull    (updFull),
    .strobes    (strobes)
  );

  unwind_dp #(.AW(AW), .MAXA(MAXA), .DEPTH(DEPTH), .ALTW(ALTW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .topAtom    (topAtom),
    .stackSize  (stackSize),
    .nodeArity  (nodeArity),
    .nodeAtoms  (nodeAtoms),
    .nodeAlts   (nodeAlts),
    .topWrEn    (topWrEn),
    .newTop     (newTop),
    .stackWrMask(stackWrMask),
    .stackWrData(stackWrData),
    .altsPush   (altsPush),
    .altsData   (altsData),
    .updPush    (updPush),
    .updData    (updData),
    .errOverflow(errOverflow)
  );
endmodule

// File: rtl/unwind_checker.sv
module unwind_checker #(
  parameter int AW   = 8,
  parameter int MAXA = 4,
  localparam int ATOMW = AW + 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             unwindReq,
  input logic [ATOMW-1:0] topAtom,
  input logic             nodeIsNf,
  input logic             updFull,
  input logic             topWrEn,
  input logic [ATOMW-1:0] newTop,
  input logic [MAXA-2:0]  stackWrMask,
  input logic             altsPush,
  input logic             updPush,
  input logic             errOverflow
);
  logic pastValid;
  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  a_r1_request_answered: assert property (@(posedge clk) disable iff (!rstN)
    unwindReq |=> (topWrEn || errOverflow));

  a_r10_no_spurious_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && (topWrEn || errOverflow || altsPush || updPush)) |-> $past(unwindReq));

  a_r3_mask_needs_top: assert property (@(posedge clk) disable iff (!rstN)
    (stackWrMask != '0) |-> topWrEn);

  a_r3_mask_contiguous: assert property (@(posedge clk) disable iff (!rstN)
    ((stackWrMask & (stackWrMask + 1'b1)) == '0));

  a_r7_no_commit_on_error: assert property (@(posedge clk) disable iff (!rstN)
    (errOverflow && !topWrEn) |-> (stackWrMask == '0 && !altsPush && !updPush));

  a_r5_update_condition: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && updPush) |-> $past(topAtom[AW+1] && !nodeIsNf && !updFull));

  a_r8_full_blocks_update: assert property (@(posedge clk) disable iff (!rstN)
    (unwindReq && topAtom[AW+1] && !nodeIsNf && updFull) |=> (!updPush && errOverflow));

  a_r6_top_dashed: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && topWrEn && $past(topAtom[AW+1])) |-> newTop[AW+1]);

  a_r4_alts_with_top: assert property (@(posedge clk) disable iff (!rstN)
    altsPush |-> topWrEn);
endmodule

bind unwind_unit unwind_checker #(.AW(AW), .MAXA(MAXA)) u_unwind_checker (
  .clk        (clk),
  .rstN       (rstN),
  .unwindReq  (unwindReq),
  .topAtom    (topAtom),
  .nodeIsNf   (nodeIsNf),
  .updFull    (updFull),
  .topWrEn    (topWrEn),
  .newTop     (newTop),
  .stackWrMask(stackWrMask),
  .altsPush   (altsPush),
  .updPush    (updPush),
  .errOverflow(errOverflow)
);

// File: tb/test_unwind_unit.sv
module test_unwind_unit;
  localparam int AW = 8, MAXA = 4, DEPTH = 16, ALTW = 8;
  localparam int ATOMW = AW + 2;
  localparam int SW = $clog2(DEPTH + 1);
  localparam int ARW = $clog2(MAXA + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic unwindReq = 1'b0;
  logic [ATOMW-1:0] topAtom = '0;
  logic [SW-1:0] stackSize = '0;
  logic [ARW-1:0] nodeArity = '0;
  logic [MAXA*ATOMW-1:0] nodeAtoms = '0;
  logic nodeHasAlts = 1'b0;
  logic [ALTW-1:0] nodeAlts = '0;
  logic nodeIsNf = 1'b0;
  logic updFull = 1'b0;
  logic topWrEn;
  logic [ATOMW-1:0] newTop;
  logic [MAXA-2:0] stackWrMask;
  logic [(MAXA-1)*ATOMW-1:0] stackWrData;
  logic altsPush;
  logic [ALTW-1:0] altsData;
  logic updPush;
  logic [SW+AW-1:0] updData;
  logic errOverflow;

  always #2.5ns clk = ~clk;

  unwind_unit #(.AW(AW), .MAXA(MAXA), .DEPTH(DEPTH), .ALTW(ALTW)) i_unwind_unit (
    .clk(clk), .rstN(rstN), .unwindReq(unwindReq), .topAtom(topAtom),
    .stackSize(stackSize), .nodeArity(nodeArity), .nodeAtoms(nodeAtoms),
    .nodeHasAlts(nodeHasAlts), .nodeAlts(nodeAlts), .nodeIsNf(nodeIsNf),
    .updFull(updFull), .topWrEn(topWrEn), .newTop(newTop),
    .stackWrMask(stackWrMask), .stackWrData(stackWrData), .altsPush(altsPush),
    .altsData(altsData), .updPush(updPush), .updData(updData),
    .errOverflow(errOverflow)
  );

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  logic expTop, expAlts, expUpd, expErr;
  logic [ATOMW-1:0] expNewTop;
  logic [MAXA-2:0] expMask;
  logic [(MAXA-1)*ATOMW-1:0] expData;
  logic [ALTW-1:0] expAltsData;
  logic [SW+AW-1:0] expUpdData;

  task automatic checkVal(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    checkVal("R2/R10 topWrEn", 64'(topWrEn), 64'(expTop));
    checkVal("R2/R6 newTop", 64'(newTop), 64'(expNewTop));
    checkVal("R3/R7 stackWrMask", 64'(stackWrMask), 64'(expMask));
    checkVal("R3/R6 stackWrData", 64'(stackWrData), 64'(expData));
    checkVal("R4 altsPush", 64'(altsPush), 64'(expAlts));
    checkVal("R4 altsData", 64'(altsData), 64'(expAltsData));
    checkVal("R5/R8 updPush", 64'(updPush), 64'(expUpd));
    checkVal("R5 updData", 64'(updData), 64'(expUpdData));
    checkVal("R7/R8/R9 errOverflow", 64'(errOverflow), 64'(expErr));
  endtask

  // Behavioural reference: expected register-stage contents after the next edge.
  task automatic predict();
    int ar, sz;
    bit ok, sh, need;
    ar = int'(nodeArity);
    sz = int'(stackSize);
    sh = topAtom[AW+1];
    need = sh && !nodeIsNf;
    ok = unwindReq && ar >= 1 && ar <= MAXA && (sz + ar - 1) <= DEPTH;
    if (!rstN) begin
      expTop = 0; expAlts = 0; expUpd = 0; expErr = 0;
      expNewTop = '0; expMask = '0; expData = '0; expAltsData = '0; expUpdData = '0;
    end else begin
      expTop = ok;
      expAlts = ok && nodeHasAlts;
      expUpd = ok && need && !updFull;
      expErr = unwindReq && (!ok || (need && updFull));
      expNewTop = nodeAtoms[0 +: ATOMW];
      if (sh) expNewTop[AW+1] = 1'b1;
      for (int i = 0; i < MAXA - 1; i++) begin
        logic [ATOMW-1:0] a;
        a = nodeAtoms[(i+1)*ATOMW +: ATOMW];
        if (sh) a[AW+1] = 1'b1;
        expData[i*ATOMW +: ATOMW] = a;
        expMask[i] = ok && (i < ar - 1);
      end
      expAltsData = nodeAlts;
      expUpdData = {stackSize, topAtom[AW-1:0]};
    end
  endtask

  task automatic step(bit rst, bit req, logic [ATOMW-1:0] top, int size, int ar,
                      logic [MAXA*ATOMW-1:0] atoms, bit hasAlts, logic [ALTW-1:0] alts,
                      bit isNf, bit full);
    @(negedge clk);
    compareAll();
    rstN = rst; unwindReq = req; topAtom = top; stackSize = SW'(size);
    nodeArity = ARW'(ar); nodeAtoms = atoms; nodeHasAlts = hasAlts;
    nodeAlts = alts; nodeIsNf = isNf; updFull = full;
    predict();
  endtask

  function automatic logic [MAXA*ATOMW-1:0] mkAtoms(int seed);
    logic [MAXA*ATOMW-1:0] r;
    for (int k = 0; k < MAXA; k++)
      r[k*ATOMW +: ATOMW] = ATOMW'(((seed + k) * 37) & 10'h1ff);
    return r;
  endfunction

  localparam logic [ATOMW-1:0] SHPTR = {2'b11, 8'h5a};
  localparam logic [ATOMW-1:0] UNPTR = {2'b01, 8'h33};

  initial begin
    #(5ns * 200000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    predict();
    // R10 reset state
    step(0, 1, SHPTR, 2, 3, mkAtoms(1), 1, 8'h11, 0, 0);
    step(0, 0, '0, 0, 0, '0, 0, '0, 0, 0);
    step(1, 0, '0, 0, 0, '0, 0, '0, 0, 0);
    // R2/R3 arity 1, unshared, no alternatives
    step(1, 1, UNPTR, 3, 1, mkAtoms(2), 0, 8'h22, 0, 0);
    // R1 idle after request
    step(1, 0, UNPTR, 3, 1, mkAtoms(2), 0, 8'h22, 0, 0);
    // R3/R4/R5/R6 full arity, shared, alternatives, not normal form
    step(1, 1, SHPTR, 5, 4, mkAtoms(3), 1, 8'h9c, 0, 0);
    // R5 shared but already normal form: no update
    step(1, 1, SHPTR, 6, 2, mkAtoms(4), 0, 8'h01, 1, 0);
    // R5 unshared, not normal form: no update
    step(1, 1, UNPTR, 6, 3, mkAtoms(5), 1, 8'h02, 0, 0);
    // R8 update stack full
    step(1, 1, SHPTR, 4, 3, mkAtoms(6), 1, 8'h03, 0, 1);
    // R7 exact fit then one beyond
    step(1, 1, SHPTR, DEPTH - 2, 3, mkAtoms(7), 0, 8'h04, 0, 0);
    step(1, 1, SHPTR, DEPTH - 1, 3, mkAtoms(8), 1, 8'h05, 0, 0);
    step(1, 1, UNPTR, DEPTH, 1, mkAtoms(9), 1, 8'h06, 0, 0);
    // R9 malformed arity
    step(1, 1, SHPTR, 2, 0, mkAtoms(10), 1, 8'h07, 0, 0);
    step(1, 1, SHPTR, 2, MAXA + 1, mkAtoms(11), 1, 8'h08, 0, 0);
    step(1, 0, '0, 0, 0, '0, 0, '0, 0, 0);
    // Random traffic
    for (int n = 0; n < 400; n++) begin
      step(1, bit'($urandom_range(0, 3) != 0), ATOMW'($urandom),
           int'($urandom_range(0, DEPTH)), int'($urandom_range(0, 7)),
           {$urandom, $urandom}, bit'($urandom), ALTW'($urandom),
           bit'($urandom), bit'($urandom_range(0, 3) == 0));
    end
    // Reset in mid-run: R10
    step(0, 1, SHPTR, 1, 2, mkAtoms(12), 1, 8'h0f, 0, 0);
    step(1, 0, '0, 0, 0, '0, 0, '0, 0, 0);
    step(1, 0, '0, 0, 0, '0, 0, '0, 0, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule